// File: doc/BRIEF.md
# Multi-Cycle Instruction Cycle Controller

This block is the control and register-transfer core of a small two-register processor. It runs each instruction as an explicit series of subcycles. Fetch always runs. An indirect operand cycle runs only when the instruction asks for it. Execute always runs. An interrupt cycle runs only when a request is pending and interrupts are enabled. The block holds the program counter, memory address register (MAR), memory buffer register (MBR), instruction register, stack pointer, two data registers and a program status word (PSW).

The block drives one single-port synchronous memory. The address always comes from the MAR and the write data always comes from the MBR. Each read or write strobe lasts one cycle and occupies its own state. Read data is valid on the cycle after the read strobe.

A level-sensitive interrupt request is sampled only at the end of an instruction. When it is taken, the hardware pushes the program counter onto a descending stack through the MBR and MAR, then jumps to a fixed handler address. A return instruction pops the saved address.

Top module: `instr_cycle_ctrl`

## Requirements
- R1: After reset, the program counter is 0, both data registers are 0, the PSW reads 7'b1000000 (supervisor set, everything else clear), both memory strobes are low, the subcycle output reads fetch (2'b00), and the stack pointer holds the all-ones address.
- R2: An instruction word carries the opcode in [DW-1:DW-4], the indirect flag in [AW+2], register A select in [AW+1], register B select in [AW] and the address field in [AW-1:0]. Fetch reads the word at the program counter and advances the counter by one. A direct instruction that reads memory takes 9 cycles from the end of one instruction to the end of the next, and a branch takes 6. Any opcode without a defined meaning (including 0) does nothing.
- R3: When the indirect flag is set, the controller reads the word at the address field and uses its low AW bits as the effective address. This adds 3 cycles, and the program counter does not change during them.
- R4: LOAD (opcode 1) copies the memory word at the effective address into register A. STORE (opcode 2) writes register A to that address.
- R5: ADD (3) and SUB (4) combine register A with the memory word and write the result back to register A. The PSW bits are [0] sign, [1] zero, [2] carry (on SUB, the borrow), [3] equal (the operands were equal) and [4] signed overflow.
- R6: Only ADD and SUB change PSW bits [4:0]. LOAD, STORE, branches and the interrupt cycle leave them unchanged.
- R7: JMP (5) always loads the effective address into the program counter. BRP (6) does so only if the last result was positive (sign clear and zero clear). BRZ (7) does so only if the zero bit is set. BRE (8) does so only if register A equals register B.
- R8: The request input is sampled only in the last execute cycle (the cycle in which retire_o is high). The interrupt subcycle (2'b11) starts in the next cycle only if the request is high and PSW bit [5] (interrupt enable) is set. Otherwise fetch (2'b00) follows.
- R9: The interrupt cycle decrements the stack pointer and then writes the return program counter to memory at the new stack pointer. It then loads the handler address, clears interrupt enable and sets PSW bit [6] (supervisor).
- R10: RTI (9) reads the program counter from memory at the stack pointer, increments the stack pointer, sets interrupt enable and clears supervisor.
- R11: EI (10) sets interrupt enable.
- R12: The read and write strobes are never high together, and a read strobe never lasts two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | DW | Memory read data, valid the cycle after mem_rd |
| mem_addr | output | AW | Memory address, driven from the MAR |
| mem_wdata | output | DW | Memory write data, driven from the MBR |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| pc_o | output | AW | Program counter |
| psw_o | output | 7 | PSW: {supervisor, int enable, overflow, equal, carry, zero, sign} |
| regs_o | output | 2*DW | Data registers, register 0 in the low half |
| phase_o | output | 2 | Current subcycle: 0 fetch, 1 indirect, 2 execute, 3 interrupt |
| retire_o | output | 1 | High in the last execute cycle of each instruction |

## Verification
The bench uses the default AW of 9, which gives a 16-bit word, and a handler address of 256. This places program, data, handler and stack in separate regions of a 512-word memory. The first interrupt push lands at address 510, so a wrong pre-decrement or a wrong pop increment shows up when a second interrupt reuses the same slot. A 16-bit word makes the boundary cases easy to reach: signed overflow from 0x7FFF plus 1, a carry out from adding 0xFFFF, and a zero result with equal operands.

// File: rtl/icc_pkg.sv
package icc_pkg;

  localparam int OP_W   = 4;
  localparam int RSEL_W = 1;
  localparam int NREG   = 2 ** RSEL_W;

  localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OP_W-1:0] OP_STORE = 4'd2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OP_W-1:0] OP_SUB   = 4'd4;
  localparam logic [OP_W-1:0] OP_JMP   = 4'd5;
  localparam logic [OP_W-1:0] OP_BRP   = 4'd6;
  localparam logic [OP_W-1:0] OP_BRZ   = 4'd7;
  localparam logic [OP_W-1:0] OP_BRE   = 4'd8;
  localparam logic [OP_W-1:0] OP_RTI   = 4'd9;
  localparam logic [OP_W-1:0] OP_EI    = 4'd10;

  localparam logic [1:0] PH_FETCH = 2'd0;
  localparam logic [1:0] PH_IND   = 2'd1;
  localparam logic [1:0] PH_EXEC  = 2'd2;
  localparam logic [1:0] PH_INT   = 2'd3;

  typedef enum logic [4:0] {
    S_FADR, S_FRD, S_FLD, S_DEC,
    S_IADR, S_IRD, S_ILD,
    S_EX, S_XRD, S_XLD, S_XALU, S_XRTI, S_XWR, S_CHK,
    S_INT1, S_INT2, S_INT3
  } cyc_state_e;

  typedef struct packed {
    logic sup;
    logic ie;
    logic ovf;
    logic eq;
    logic cy;
    logic z;
    logic s;
  } psw_t;

endpackage

// File: rtl/icc_alu.sv
module icc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          f_s,
  output logic          f_z,
  output logic          f_cy,
  output logic          f_eq,
  output logic          f_ovf
);

  function automatic logic [DW:0] add_sub(input logic [DW-1:0] x, input logic [DW-1:0] y,
                                          input logic do_sub);
    logic [DW:0] wide;
    if (do_sub) wide = {1'b0, x} - {1'b0, y};
    else        wide = {1'b0, x} + {1'b0, y};
    return wide;
  endfunction

  function automatic logic signed_ovf(input logic xm, input logic ym, input logic rm,
                                      input logic do_sub);
    logic ym_eff;
    ym_eff = do_sub ? ~ym : ym;
    return (xm == ym_eff) && (rm != xm);
  endfunction

  logic [DW:0] wide;

  always_comb begin
    wide  = add_sub(a, b, sub);
    res   = wide[DW-1:0];
    f_cy  = wide[DW];
    f_s   = wide[DW-1];
    f_z   = (wide[DW-1:0] == '0);
    f_eq  = (a == b);
    f_ovf = signed_ovf(a[DW-1], b[DW-1], wide[DW-1], sub);
  end

endmodule

// File: rtl/icc_branch_eval.sv
module icc_branch_eval
  import icc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [OP_W-1:0] op,
  input  psw_t            psw,
  input  logic [DW-1:0]   ra_val,
  input  logic [DW-1:0]   rb_val,
  output logic            take
);

  always_comb begin
    unique case (op)
      OP_JMP:  take = 1'b1;
      OP_BRP:  take = !psw.s && !psw.z;
      OP_BRZ:  take = psw.z;
      OP_BRE:  take = (ra_val == rb_val);
      default: take = 1'b0;
    endcase
  end

endmodule

// File: rtl/instr_cycle_ctrl.sv
module instr_cycle_ctrl
  import icc_pkg::*;
#(
  parameter  int AW       = 9,
  parameter  int ISR_ADDR = 256,
  localparam int DW       = OP_W + 3 + AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq,
  input  logic [DW-1:0]      mem_rdata,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [AW-1:0]      pc_o,
  output logic [6:0]         psw_o,
  output logic [NREG*DW-1:0] regs_o,
  output logic [1:0]         phase_o,
  output logic               retire_o
);

  localparam logic [AW-1:0] ISR_VEC = AW'(ISR_ADDR);
  localparam logic [AW-1:0] SP_TOP  = '1;
  localparam int            IND_BIT = AW + 2;
  localparam int            RA_BIT  = AW + 1;
  localparam int            RB_BIT  = AW;

  cyc_state_e    state;
  logic [AW-1:0] pc, mar, sp;
  logic [DW-1:0] mbr, ir;
  psw_t          psw_q;
  logic [DW-1:0] regs [NREG];

  // instruction fields
  logic [OP_W-1:0] ir_op;
  logic            ir_ind;
  logic            ir_ra, ir_rb;
  logic [AW-1:0]   ir_addr;
  assign ir_op   = ir[DW-1 -: OP_W];
  assign ir_ind  = ir[IND_BIT];
  assign ir_ra   = ir[RA_BIT];
  assign ir_rb   = ir[RB_BIT];
  assign ir_addr = ir[AW-1:0];

  // effective address: indirect result sits in MBR, direct comes from IR
  logic [AW-1:0] eff_addr;
  assign eff_addr = ir_ind ? mbr[AW-1:0] : ir_addr;

  // named internal events
  logic retire, irq_accept, br_take, push_fire, pop_fire, alu_write;
  assign retire     = (state == S_CHK);
  assign irq_accept = retire && irq && psw_q.ie;
  assign push_fire  = (state == S_INT3);
  assign pop_fire   = (state == S_XRTI);
  assign alu_write  = (state == S_XALU) && (ir_op != OP_LOAD);

  logic [DW-1:0] alu_res;
  logic          a_s, a_z, a_cy, a_eq, a_ovf;

  icc_alu #(.DW(DW)) u_alu (
    .a     (regs[ir_ra]),
    .b     (mbr),
    .sub   (ir_op == OP_SUB),
    .res   (alu_res),
    .f_s   (a_s),
    .f_z   (a_z),
    .f_cy  (a_cy),
    .f_eq  (a_eq),
    .f_ovf (a_ovf)
  );

  icc_branch_eval #(.DW(DW)) u_br (
    .op     (ir_op),
    .psw    (psw_q),
    .ra_val (regs[ir_ra]),
    .rb_val (regs[ir_rb]),
    .take   (br_take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_FADR;
      pc    <= '0;
      mar   <= '0;
      mbr   <= '0;
      ir    <= '0;
      sp    <= SP_TOP;
      psw_q <= '{sup: 1'b1, default: 1'b0};
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      unique case (state)
        S_FADR: begin mar <= pc; state <= S_FRD; end
        S_FRD:  begin pc <= pc + 1'b1; state <= S_FLD; end
        S_FLD:  begin mbr <= mem_rdata; state <= S_DEC; end
        S_DEC: begin
          ir    <= mbr;
          state <= mbr[IND_BIT] ? S_IADR : S_EX;
        end
        S_IADR: begin mar <= mbr[AW-1:0]; state <= S_IRD; end
        S_IRD:  state <= S_ILD;
        S_ILD:  begin mbr <= mem_rdata; state <= S_EX; end
        S_EX: begin
          unique case (ir_op)
            OP_LOAD, OP_ADD, OP_SUB: begin mar <= eff_addr; state <= S_XRD; end
            OP_STORE: begin
              mar   <= eff_addr;
              mbr   <= regs[ir_ra];
              state <= S_XWR;
            end
            OP_RTI: begin mar <= sp; state <= S_XRD; end
            OP_JMP, OP_BRP, OP_BRZ, OP_BRE: begin
              if (br_take) pc <= eff_addr;
              state <= S_CHK;
            end
            OP_EI: begin psw_q.ie <= 1'b1; state <= S_CHK; end
            default: state <= S_CHK;
          endcase
        end
        S_XRD: state <= S_XLD;
        S_XLD: begin
          mbr   <= mem_rdata;
          state <= (ir_op == OP_RTI) ? S_XRTI : S_XALU;
        end
        S_XALU: begin
          if (alu_write) begin
            regs[ir_ra] <= alu_res;
            psw_q.s     <= a_s;
            psw_q.z     <= a_z;
            psw_q.cy    <= a_cy;
            psw_q.eq    <= a_eq;
            psw_q.ovf   <= a_ovf;
          end else begin
            regs[ir_ra] <= mbr;
          end
          state <= S_CHK;
        end
        S_XRTI: begin
          pc        <= mbr[AW-1:0];
          sp        <= sp + 1'b1;
          psw_q.ie  <= 1'b1;
          psw_q.sup <= 1'b0;
          state     <= S_CHK;
        end
        S_XWR: state <= S_CHK;
        S_CHK: state <= irq_accept ? S_INT1 : S_FADR;
        S_INT1: begin
          mbr   <= {{(DW-AW){1'b0}}, pc};
          sp    <= sp - 1'b1;
          state <= S_INT2;
        end
        S_INT2: begin mar <= sp; state <= S_INT3; end
        S_INT3: begin
          pc        <= ISR_VEC;
          psw_q.ie  <= 1'b0;
          psw_q.sup <= 1'b1;
          state     <= S_FADR;
        end
        default: state <= S_FADR;
      endcase
    end
  end

  // memory interface
  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = (state == S_FRD) || (state == S_IRD) || (state == S_XRD);
  assign mem_wr    = (state == S_XWR) || push_fire;

  // observation
  always_comb begin
    unique case (state)
      S_FADR, S_FRD, S_FLD, S_DEC: phase_o = PH_FETCH;
      S_IADR, S_IRD, S_ILD:        phase_o = PH_IND;
      S_INT1, S_INT2, S_INT3:      phase_o = PH_INT;
      default:                     phase_o = PH_EXEC;
    endcase
  end

  assign pc_o     = pc;
  assign psw_o    = psw_q;
  assign retire_o = retire;

  for (genvar g = 0; g < NREG; g++) begin : g_regs_out
    assign regs_o[g*DW +: DW] = regs[g];
  end

endmodule

// File: rtl/icc_checker.sv
module icc_checker
  import icc_pkg::*;
#(
  parameter int AW       = 9,
  parameter int ISR_ADDR = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [1:0]    phase,
  input logic          retire,
  input logic          irq_accept,
  input logic          pop_fire,
  input logic [6:0]    psw,
  input logic [AW-1:0] pc
);

  localparam logic [AW-1:0] ISR_VEC = AW'(ISR_ADDR);

  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_rd_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_int_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> (phase == PH_INT));

  p_no_int_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !(irq && psw[5])) |=> (phase == PH_FETCH));

  p_int_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase == PH_INT) |-> (!psw[5] && psw[6] && pc == ISR_VEC));

  p_pc_hold_ind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IND) |-> $stable(pc));

  p_flags_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_EXEC) |=> $stable(psw[4:0]));

  p_rti_ie_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |=> (psw[5] && !psw[6]));

endmodule

bind instr_cycle_ctrl icc_checker #(.AW(AW), .ISR_ADDR(ISR_ADDR)) u_icc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq        (irq),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .phase      (phase_o),
  .retire     (retire_o),
  .irq_accept (irq_accept),
  .pop_fire   (pop_fire),
  .psw        (psw_o),
  .pc         (pc_o)
);

// File: tb/tb_instr_cycle_ctrl.sv
module tb_instr_cycle_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 9;
  localparam int DW    = 16;
  localparam int ISR   = 256;
  localparam int MSIZE = 512;
  localparam int MAXC  = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_rd, mem_wr;
  logic [AW-1:0] pc_o;
  logic [6:0]    psw_o;
  logic [2*DW-1:0] regs_o;
  logic [1:0]    phase_o;
  logic          retire_o;

  instr_cycle_ctrl #(.AW(AW), .ISR_ADDR(ISR)) dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc_o(pc_o), .psw_o(psw_o), .regs_o(regs_o), .phase_o(phase_o), .retire_o(retire_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [DW-1:0] mem     [MSIZE];
  logic [DW-1:0] ref_mem [MSIZE];

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
  end

  int n_chk = 0, n_fail = 0;
  int cyc = 0, n_ret = 0, last_ret_cyc = 0, int_entries = 0;
  bit timeout = 0;
  logic [1:0] prev_phase = 2'd0;

  // reference state
  int m_pc = 0, m_sp = MSIZE - 1;
  int m_r [2];
  bit m_s, m_z, m_cy, m_eq, m_ov, m_ie, m_sup;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(input int op, input int ind, input int ra,
                                        input int rb, input int addr);
    return {op[3:0], ind[0], ra[0], rb[0], addr[AW-1:0]};
  endfunction

  function automatic int sgn(input int v);
    return (v >= 32768) ? v - 65536 : v;
  endfunction

  function automatic logic [6:0] m_psw();
    return {m_sup, m_ie, m_ov, m_eq, m_cy, m_z, m_s};
  endfunction

  function automatic string req_of(input int op);
    case (op)
      1, 2:       return "R4";
      3, 4:       return "R5";
      5, 6, 7, 8: return "R7";
      9:          return "R10";
      10:         return "R11";
      default:    return "R2";
    endcase
  endfunction

  // executes one instruction on the reference state; returns its opcode
  function automatic int ref_step();
    int ins, op, ind, ra, rb, a, x, y, t, sr;
    ins = ref_mem[m_pc];
    m_pc = (m_pc + 1) % MSIZE;
    op = ins >> 12; ind = (ins >> 11) & 1; ra = (ins >> 10) & 1; rb = (ins >> 9) & 1;
    a = ins % MSIZE;
    if (ind != 0) a = ref_mem[a] % MSIZE;
    case (op)
      1: m_r[ra] = ref_mem[a];
      2: ref_mem[a] = m_r[ra][15:0];
      3, 4: begin
        x = m_r[ra]; y = ref_mem[a];
        if (op == 3) begin t = x + y; sr = sgn(x) + sgn(y); m_cy = (t > 65535); end
        else         begin t = x - y; sr = sgn(x) - sgn(y); m_cy = (x < y); end
        t = t & 16'hFFFF;
        m_r[ra] = t;
        m_s = (t >= 32768); m_z = (t == 0); m_eq = (x == y);
        m_ov = (sr > 32767) || (sr < -32768);
      end
      5: m_pc = a;
      6: if (!m_s && !m_z) m_pc = a;
      7: if (m_z) m_pc = a;
      8: if (m_r[ra] == m_r[rb]) m_pc = a;
      9: begin
        m_pc = ref_mem[m_sp] % MSIZE;
        m_sp = (m_sp + 1) % MSIZE;
        m_ie = 1; m_sup = 0;
      end
      10: m_ie = 1;
      default: ;
    endcase
    return op;
  endfunction

  // per-clock monitor and instruction-level comparison
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        cyc++;
        chk("R12", "strobes exclusive", {31'd0, mem_rd && mem_wr}, 32'd0);
        if (phase_o == 2'd3 && prev_phase != 2'd3) int_entries++;
        prev_phase = phase_o;
        if (retire_o) begin
          int op, len;
          bit mem_ok;
          n_ret++;
          len = cyc - last_ret_cyc;
          last_ret_cyc = cyc;
          op = ref_step();
          chk(req_of(op), "pc", {23'd0, pc_o}, m_pc);
          chk(req_of(op), "r0", {16'd0, regs_o[15:0]}, m_r[0]);
          chk(req_of(op), "r1", {16'd0, regs_o[31:16]}, m_r[1]);
          chk((op == 3 || op == 4) ? "R5" : "R6", "psw", {25'd0, psw_o}, {25'd0, m_psw()});
          mem_ok = 1;
          for (int i = 0; i < MSIZE; i++) if (mem[i] !== ref_mem[i]) mem_ok = 0;
          chk("R4", "memory image", {31'd0, mem_ok}, 32'd1);
          if (n_ret == 2)  chk("R2", "direct ADD length", len, 9);
          if (n_ret == 5)  chk("R2", "branch length", len, 6);
          if (n_ret == 7)  chk("R3", "indirect LOAD length", len, 12);
          if (n_ret == 9)  chk("R3", "indirect STORE length", len, 10);
          if (n_ret == 14) chk("R8", "masked request ignored", int_entries, 0);
          if (irq && m_ie) begin
            m_sp = (m_sp + MSIZE - 1) % MSIZE;
            ref_mem[m_sp] = m_pc[15:0];
            m_pc = ISR; m_ie = 0; m_sup = 1;
          end
        end
        if (cyc > MAXC) timeout = 1;
      end
    end
  end

  // interrupt request driver
  initial begin
    irq = 1'b1;   // pending while interrupts are still disabled
    wait (n_ret >= 6);
    @(posedge clk); #1 irq = 1'b0;
    wait (n_ret >= 20);
    @(posedge clk); #1 irq = 1'b1;
    wait (phase_o == 2'd3);
    @(posedge clk); #1 irq = 1'b0;
    wait (n_ret >= 32);
    @(posedge clk); #1 irq = 1'b1;
    wait (phase_o == 2'd3);
    @(posedge clk); #1 irq = 1'b0;
  end

  initial begin
    for (int i = 0; i < MSIZE; i++) mem[i] = '0;
    mem[0]  = enc(1, 0, 0, 0, 'h80);   // LOAD r0,[80]
    mem[1]  = enc(3, 0, 0, 0, 'h81);   // ADD r0,[81] -> overflow
    mem[2]  = enc(1, 0, 1, 0, 'h82);   // LOAD r1,[82]
    mem[3]  = enc(4, 0, 1, 0, 'h85);   // SUB r1,[85] -> zero, equal
    mem[4]  = enc(7, 0, 0, 0, 7);      // BRZ taken
    mem[5]  = enc(1, 0, 0, 0, 'h80);
    mem[7]  = enc(6, 0, 0, 0, 'h20);   // BRP not taken
    mem[8]  = enc(1, 1, 0, 0, 'h83);   // LOAD r0,@83
    mem[9]  = enc(2, 0, 0, 0, 'h86);   // STORE r0,[86]
    mem[10] = enc(2, 1, 1, 0, 'h87);   // STORE r1,@87
    mem[11] = enc(1, 0, 1, 0, 'h84);   // LOAD r1,[84]
    mem[12] = enc(8, 0, 0, 1, 15);     // BRE taken
    mem[15] = enc(4, 0, 0, 0, 'h81);   // SUB r0,[81]
    mem[16] = enc(6, 0, 0, 0, 18);     // BRP taken
    mem[18] = enc(10, 0, 0, 0, 0);     // EI
    mem[19] = enc(3, 0, 1, 0, 'h81);   // ADD r1,[81]
    mem[20] = enc(5, 0, 0, 0, 20);     // JMP self
    mem['h80] = 16'h7FFF; mem['h81] = 16'h0001; mem['h82] = 16'h0005;
    mem['h83] = 16'h0084; mem['h84] = 16'h1234; mem['h85] = 16'h0005;
    mem['h86] = 16'hDEAD; mem['h87] = 16'h0088; mem['h88] = 16'hBEEF;
    mem['h89] = 16'hFFFF;
    mem[ISR]     = enc(3, 0, 1, 0, 'h89);  // ADD r1,[89] -> carry
    mem[ISR + 1] = enc(9, 0, 0, 0, 0);     // RTI
    for (int i = 0; i < MSIZE; i++) ref_mem[i] = mem[i];
    m_r[0] = 0; m_r[1] = 0;
    m_s = 0; m_z = 0; m_cy = 0; m_eq = 0; m_ov = 0; m_ie = 0; m_sup = 1;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc", {23'd0, pc_o}, 0);
    chk("R1", "psw", {25'd0, psw_o}, 32'h40);
    chk("R1", "regs", regs_o, 0);
    chk("R1", "strobes", {30'd0, mem_rd, mem_wr}, 0);
    chk("R1", "phase", {30'd0, phase_o}, 0);

    wait (n_ret >= 50 || timeout);
    if (timeout) chk("R2", "watchdog expired", 1, 0);
    chk("R9", "interrupt entries", int_entries, 2);
    chk("R9", "pushed return address", {16'd0, mem[MSIZE-2]}, 20);
    chk("R10", "stack slot reused", {16'd0, mem[MSIZE-3]}, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule